// File: doc/BRIEF.md
# Control-Word Driven Shared-Bus Datapath

This block is a general-purpose datapath that carries out one horizontal control word in each clock cycle. It holds an eight-entry register file with two read ports and one write port, a loadable counter, an auxiliary register, an ALU, a barrel shifter, a magnitude comparator and an output port register. An external sequencer, which is not part of this block, supplies the 32-bit control word together with a data input port. Every field of the word drives one control line of one unit directly, so no decoding stage lies between the word and the hardware.

Two operand buses carry the register-file reads. The ALU, the shifter and the comparator all take their operands from these two buses. A single result bus collects the output of whichever unit the word enables. That unit may be the ALU, the shifter, the counter, the auxiliary register or the input port. The register file, the counter, the auxiliary register and the output port all load from the result bus.

If a word enables more than one result-bus driver, the word is illegal. The bus then resolves the conflict by a fixed priority and raises an error flag.

Field layout of the control word, by bit position:

| Bits | Field |
|------|-------|
| [2:0] | register-file write address |
| [3] | register-file write enable |
| [6:4] | operand A read address |
| [7] | operand A read enable |
| [10:8] | operand B read address |
| [11] | operand B read enable |
| [14:12] | ALU function |
| [15] | ALU drives the result bus |
| [18:16] | shift amount |
| [19] | shift direction (1 = left) |
| [20] | shifter drives the result bus |
| [21] | counter clear |
| [22] | counter load |
| [23] | counter increment |
| [24] | counter drives the result bus |
| [25] | auxiliary register clear |
| [26] | auxiliary register load |
| [27] | auxiliary register drives the result bus |
| [28] | input port drives the result bus |
| [29] | output port load |
| [30] | arithmetic right shift |
| [31] | signed compare |

Top module: `ctrlword_datapath`

## Requirements
- R1: After the active-low reset, the output port, the counter, the auxiliary register and all eight register-file entries read as zero.
- R2: Register-file writes take effect at the clock edge. A read of the entry being written in the same cycle returns the old value. A read port whose enable is clear puts zero on its operand bus.
- R3: The ALU function field selects one of eight operations on operand A and operand B, all modulo 2^W: 0 = A+B, 1 = A-B, 2 = A AND B, 3 = A OR B, 4 = A XOR B, 5 = A, 6 = B, 7 = A+1.
- R4: The shifter shifts operand A by 0 to 7 places. With bit 19 set it shifts left. With bit 19 clear it shifts right, logically when bit 30 is clear and arithmetically (sign-filling) when bit 30 is set.
- R5: The counter gives clear priority over load, and load priority over increment. Load takes the value on the result bus. Increment adds one, wrapping modulo 2^W.
- R6: The auxiliary register is cleared by bit 25 and loaded from the result bus by bit 26, with clear taking priority. Otherwise it holds its value.
- R7: The comparator flags compare operand A with operand B. Exactly one of greater, equal and less is high at any time. The comparison is unsigned when bit 31 is clear and two's-complement when bit 31 is set.
- R8: The output port takes the result-bus value at the clock edge when bit 29 is set, and holds its value otherwise.
- R9: If two or more result-bus drivers are enabled, the bus takes the value of the highest-priority driver and the error output is high for that cycle. The priority order, from highest, is ALU, shifter, counter, auxiliary register, input port. With no driver enabled the bus is zero. With at most one driver enabled the error output is low.
- R10: With bit 28 set, the input port value is placed on the result bus, so it can be written into the register file or the other registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 32 | Control word for the current cycle |
| in_port | input | W | External data input |
| out_port | output | W | Output port register |
| flag_gt | output | 1 | Operand A greater than operand B |
| flag_eq | output | 1 | Operand A equal to operand B |
| flag_lt | output | 1 | Operand A less than operand B |
| bus_err | output | 1 | More than one result-bus driver enabled |

## Verification
The hardest situations to reach from the ports are the same-cycle read and write of one register-file entry, and the illegal words that enable several result-bus drivers at once. Both are only visible through values that pass through the register file and then on to the output port.

The bench first loads known operands through the input port. It then issues an increment that reads and writes the same entry in one word, and checks both the value produced in that cycle and the value stored afterwards. Words with several drivers enabled are built over operand values chosen so that each candidate driver would leave a different value on the output port. The error output is sampled before the clock edge in the same cycle.

// File: rtl/ctrlword_datapath.sv
module ctrlword_datapath #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  ctrl,
  input  logic [W-1:0] in_port,
  output logic [W-1:0] out_port,
  output logic         flag_gt,
  output logic         flag_eq,
  output logic         flag_lt,
  output logic         bus_err
);
  localparam int AW = 3;
  localparam int SW = 3;

  logic [AW-1:0] wr_addr, rda, rdb;
  logic          wr_en, rda_en, rdb_en;
  logic [2:0]    alu_fn;
  logic          alu_oe, sh_oe, sh_left, sh_arith;
  logic [SW-1:0] sh_amt;
  logic          cnt_clr, cnt_ld, cnt_inc, cnt_oe;
  logic          aux_clr, aux_ld, aux_oe;
  logic          in_oe, out_ld, cmp_signed;

  assign wr_addr    = ctrl[2:0];
  assign wr_en      = ctrl[3];
  assign rda        = ctrl[6:4];
  assign rda_en     = ctrl[7];
  assign rdb        = ctrl[10:8];
  assign rdb_en     = ctrl[11];
  assign alu_fn     = ctrl[14:12];
  assign alu_oe     = ctrl[15];
  assign sh_amt     = ctrl[18:16];
  assign sh_left    = ctrl[19];
  assign sh_oe      = ctrl[20];
  assign cnt_clr    = ctrl[21];
  assign cnt_ld     = ctrl[22];
  assign cnt_inc    = ctrl[23];
  assign cnt_oe     = ctrl[24];
  assign aux_clr    = ctrl[25];
  assign aux_ld     = ctrl[26];
  assign aux_oe     = ctrl[27];
  assign in_oe      = ctrl[28];
  assign out_ld     = ctrl[29];
  assign sh_arith   = ctrl[30];
  assign cmp_signed = ctrl[31];

  logic [W-1:0] rf [NREG];
  logic [W-1:0] cnt_q, aux_q;
  logic [W-1:0] opa, opb, alu_y, sh_y, res_bus;

  assign opa = rda_en ? rf[rda] : '0;
  assign opb = rdb_en ? rf[rdb] : '0;

  always_comb begin
    case (alu_fn)
      3'd0:    alu_y = opa + opb;
      3'd1:    alu_y = opa - opb;
      3'd2:    alu_y = opa & opb;
      3'd3:    alu_y = opa | opb;
      3'd4:    alu_y = opa ^ opb;
      3'd5:    alu_y = opa;
      3'd6:    alu_y = opb;
      default: alu_y = opa + 1'b1;
    endcase
  end

  always_comb begin
    if (sh_left)       sh_y = opa << sh_amt;
    else if (sh_arith) sh_y = W'($signed(opa) >>> sh_amt);
    else               sh_y = opa >> sh_amt;
  end

  always_comb begin
    if (alu_oe)      res_bus = alu_y;
    else if (sh_oe)  res_bus = sh_y;
    else if (cnt_oe) res_bus = cnt_q;
    else if (aux_oe) res_bus = aux_q;
    else if (in_oe)  res_bus = in_port;
    else             res_bus = '0;
  end

  assign bus_err = $countones({alu_oe, sh_oe, cnt_oe, aux_oe, in_oe}) > 1;

  assign flag_eq = (opa == opb);
  assign flag_gt = cmp_signed ? ($signed(opa) > $signed(opb)) : (opa > opb);
  assign flag_lt = !flag_eq && !flag_gt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wr_addr] <= res_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_ld)  cnt_q <= res_bus;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       aux_q <= '0;
    else if (aux_clr) aux_q <= '0;
    else if (aux_ld)  aux_q <= res_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_port <= '0;
    else if (out_ld) out_port <= res_bus;
  end
endmodule

// File: rtl/ctrlword_datapath_chk.sv
module ctrlword_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [31:0]  ctrl,
  input logic [W-1:0] res_bus,
  input logic [W-1:0] alu_y,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] out_port,
  input logic         flag_gt,
  input logic         flag_eq,
  input logic         flag_lt,
  input logic         bus_err
);
  logic [4:0] drivers;
  assign drivers = {ctrl[15], ctrl[20], ctrl[24], ctrl[27], ctrl[28]};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[29] |=> $stable(out_port)); // R8
  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[29] |=> out_port == $past(res_bus)); // R8
  AST_ALU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[15] |-> res_bus == alu_y); // R9
  AST_NO_FALSE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(drivers) <= 1) |-> !bus_err); // R9
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (drivers == 5'b0) |-> res_bus == '0); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[21] |=> cnt_q == '0); // R5
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_gt, flag_eq, flag_lt}) == 1); // R7
endmodule

bind ctrlword_datapath ctrlword_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .res_bus(res_bus), .alu_y(alu_y),
  .cnt_q(cnt_q), .out_port(out_port), .flag_gt(flag_gt), .flag_eq(flag_eq),
  .flag_lt(flag_lt), .bus_err(bus_err)
);

// File: tb/ctrlword_datapath_tb.sv
`timescale 1ns/1ps
module ctrlword_datapath_tb;
  localparam int W = 16;

  localparam logic [31:0] WE     = 32'h1 << 3;
  localparam logic [31:0] RAE    = 32'h1 << 7;
  localparam logic [31:0] RBE    = 32'h1 << 11;
  localparam logic [31:0] ALUOE  = 32'h1 << 15;
  localparam logic [31:0] SHL    = 32'h1 << 19;
  localparam logic [31:0] SHOE   = 32'h1 << 20;
  localparam logic [31:0] CCLR   = 32'h1 << 21;
  localparam logic [31:0] CLD    = 32'h1 << 22;
  localparam logic [31:0] CINC   = 32'h1 << 23;
  localparam logic [31:0] COE    = 32'h1 << 24;
  localparam logic [31:0] XCLR   = 32'h1 << 25;
  localparam logic [31:0] XLD    = 32'h1 << 26;
  localparam logic [31:0] XOE    = 32'h1 << 27;
  localparam logic [31:0] INOE   = 32'h1 << 28;
  localparam logic [31:0] OUTLD  = 32'h1 << 29;
  localparam logic [31:0] SHAR   = 32'h1 << 30;
  localparam logic [31:0] CMPS   = 32'h1 << 31;

  logic clk = 0, rst_n = 0;
  logic [31:0] ctrl = '0;
  logic [W-1:0] in_port = '0;
  logic [W-1:0] out_port;
  logic flag_gt, flag_eq, flag_lt, bus_err;
  logic s_gt, s_eq, s_lt, s_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ctrlword_datapath #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .in_port(in_port),
    .out_port(out_port), .flag_gt(flag_gt), .flag_eq(flag_eq),
    .flag_lt(flag_lt), .bus_err(bus_err)
  );

  function automatic logic [31:0] wr(int a);  return WE  | (32'(a) << 0); endfunction
  function automatic logic [31:0] ra(int a);  return RAE | (32'(a) << 4); endfunction
  function automatic logic [31:0] rb(int a);  return RBE | (32'(a) << 8); endfunction
  function automatic logic [31:0] alu(int f); return ALUOE | (32'(f) << 12); endfunction
  function automatic logic [31:0] sh(int n);  return SHOE | (32'(n) << 16); endfunction

  task automatic ck(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic exec(logic [31:0] w, logic [W-1:0] v);
    @(negedge clk);
    ctrl = w; in_port = v;
    #1;
    s_gt = flag_gt; s_eq = flag_eq; s_lt = flag_lt; s_err = bus_err;
    @(posedge clk);
    #1;
  endtask

  task automatic load_reg(int r, logic [W-1:0] v);
    exec(INOE | wr(r), v);
  endtask

  task automatic show_reg(int r);
    exec(alu(5) | ra(r) | OUTLD, '0);
  endtask

  task automatic t_reset();
    #1;
    ck("R1 out after reset", out_port, '0);
    for (int r = 0; r < 8; r++) begin
      show_reg(r);
      ck("R1 reg after reset", out_port, '0);
    end
    exec(COE | OUTLD, '0);
    ck("R1 counter after reset", out_port, '0);
    exec(XOE | OUTLD, '0);
    ck("R1 aux after reset", out_port, '0);
  endtask

  task automatic t_input_and_rf();
    load_reg(1, 16'h80F0);
    load_reg(2, 16'h0FF3);
    exec(INOE | OUTLD, 16'hBEEF);
    ck("R10 input to out", out_port, 16'hBEEF);
    show_reg(1);
    ck("R10 input into reg1", out_port, 16'h80F0);
    exec(alu(7) | ra(1) | wr(1) | OUTLD, '0);
    ck("R2 same-cycle read is old", out_port, 16'h80F1);
    show_reg(1);
    ck("R2 write visible next", out_port, 16'h80F1);
    load_reg(1, 16'h80F0);
    exec(alu(0) | RBE | (32'd2 << 8) | OUTLD, '0);
    ck("R2 disabled port A zero", out_port, 16'h0FF3);
  endtask

  task automatic t_alu();
    logic [W-1:0] a = 16'h80F0, b = 16'h0FF3;
    logic [W-1:0] exp [8];
    exp[0] = a + b; exp[1] = a - b; exp[2] = a & b; exp[3] = a | b;
    exp[4] = a ^ b; exp[5] = a; exp[6] = b; exp[7] = a + 1'b1;
    for (int f = 0; f < 8; f++) begin
      exec(alu(f) | ra(1) | rb(2) | OUTLD, '0);
      ck($sformatf("R3 alu fn %0d", f), out_port, exp[f]);
    end
    exec(alu(1) | ra(2) | rb(1) | OUTLD, '0);
    ck("R3 sub wraps", out_port, b - a);
  endtask

  task automatic t_shift();
    exec(sh(4) | SHL | ra(1) | OUTLD, '0);
    ck("R4 left 4", out_port, 16'h0F00);
    exec(sh(4) | ra(1) | OUTLD, '0);
    ck("R4 logical right 4", out_port, 16'h080F);
    exec(sh(4) | SHAR | ra(1) | OUTLD, '0);
    ck("R4 arith right 4", out_port, 16'hF80F);
    exec(sh(7) | SHAR | ra(2) | OUTLD, '0);
    ck("R4 arith right positive", out_port, 16'h001F);
    exec(sh(0) | ra(1) | OUTLD, '0);
    ck("R4 shift 0", out_port, 16'h80F0);
  endtask

  task automatic t_counter();
    exec(INOE | CLD, 16'hFFFE);
    exec(CINC, '0);
    exec(COE | OUTLD, '0);
    ck("R5 load then inc", out_port, 16'hFFFF);
    exec(CINC, '0);
    exec(COE | OUTLD, '0);
    ck("R5 wrap", out_port, 16'h0000);
    exec(INOE | CLD | CINC, 16'h0042);
    exec(COE | OUTLD, '0);
    ck("R5 load beats inc", out_port, 16'h0042);
    exec(INOE | CCLR | CLD | CINC, 16'h0077);
    exec(COE | OUTLD, '0);
    ck("R5 clear beats load", out_port, 16'h0000);
  endtask

  task automatic t_aux();
    exec(INOE | XLD, 16'h1357);
    exec('0, 16'hAAAA);
    exec(XOE | OUTLD, '0);
    ck("R6 aux load and hold", out_port, 16'h1357);
    exec(INOE | XLD | XCLR, 16'h2468);
    exec(XOE | OUTLD, '0);
    ck("R6 clear beats load", out_port, 16'h0000);
  endtask

  task automatic t_compare();
    exec(ra(1) | rb(2), '0);
    ck("R7 unsigned gt", {s_gt, s_eq, s_lt}, 3'b100);
    exec(ra(1) | rb(2) | CMPS, '0);
    ck("R7 signed lt", {s_gt, s_eq, s_lt}, 3'b001);
    exec(ra(2) | rb(2), '0);
    ck("R7 equal", {s_gt, s_eq, s_lt}, 3'b010);
    exec(ra(2) | rb(1), '0);
    ck("R7 unsigned lt", {s_gt, s_eq, s_lt}, 3'b001);
  endtask

  task automatic t_out_hold();
    exec(INOE | OUTLD, 16'h5A5A);
    exec(alu(5) | ra(1), '0);
    ck("R8 hold without load", out_port, 16'h5A5A);
    exec(INOE | wr(3), 16'h1111);
    ck("R8 hold during write", out_port, 16'h5A5A);
  endtask

  task automatic t_conflict();
    exec(INOE | XLD, 16'h3333);
    exec(INOE | CLD, 16'h4444);
    exec(alu(6) | rb(2) | INOE | OUTLD, 16'h7777);
    ck("R9 alu beats input", out_port, 16'h0FF3);
    ck("R9 err alu+in", {15'b0, s_err}, 16'h1);
    exec(sh(4) | ra(1) | COE | XOE | OUTLD, '0);
    ck("R9 shifter beats counter", out_port, 16'h080F);
    ck("R9 err sh+cnt", {15'b0, s_err}, 16'h1);
    exec(COE | XOE | INOE | OUTLD, 16'h9999);
    ck("R9 counter beats aux", out_port, 16'h4444);
    exec(XOE | INOE | OUTLD, 16'h9999);
    ck("R9 aux beats input", out_port, 16'h3333);
    exec(alu(5) | ra(1) | OUTLD, '0);
    ck("R9 single driver no err", {15'b0, s_err}, 16'h0);
    exec(OUTLD, 16'hFFFF);
    ck("R9 idle bus zero", out_port, 16'h0000);
    ck("R9 idle no err", {15'b0, s_err}, 16'h0);
  endtask

  initial begin
    #10; rst_n = 1;
    t_reset();
    t_input_and_rf();
    t_alu();
    t_shift();
    t_counter();
    t_aux();
    t_compare();
    t_out_hold();
    t_conflict();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule